// File: doc/BRIEF.md
# Single-Slot Packet Timestamp Capture

This block records the value of a free-running time counter at the moment a packet marked for timestamping crosses the wire. A one-cycle event pulse from the packet path causes the current counter value to be written into a single storage slot. A valid flag then marks the slot as occupied. While the slot is occupied, later event pulses are refused and counted as drops. Because of this, a stored stamp always belongs to exactly one packet.

Software reads the stamp one 32-bit word at a time, low word first. Reading the high word frees the slot and rearms the capture. When the counter runs in seconds/nanoseconds format, the high word carries the seconds and the low word the nanoseconds.

The same design is instantiated once for transmit and once for receive. Clearing the enable input turns capture off and wipes the slot.

Top module: `ts_capture`

## Requirements
- R1: After reset, `valid_o` is 0, `drop_cnt_o` is 0 and `rd_data_o` is 0.
- R2: While `cap_en_i` is 0, no capture takes place. At each such edge the valid flag and the stored stamp are cleared, so a later low-word read returns 0. The drop counter is left unchanged.
- R3: On a clock edge with `cap_en_i`=1, `evt_i`=1, the slot empty and no high-word read, `time_i` from that edge is stored and `valid_o` is 1 from the next cycle.
- R4: While the slot is occupied, an event leaves the stored stamp and `valid_o` unchanged.
- R5: A read with `rd_en_i`=1 and `rd_hi_i`=0 returns bits 31:0 of the stored stamp on `rd_data_o` in the following cycle. It does not change the valid flag.
- R6: A read with `rd_en_i`=1 and `rd_hi_i`=1 returns bits 63:32 of the stored stamp in the following cycle and clears `valid_o`. The next event is then captured.
- R7: An event in the same cycle as a high-word read is not captured, so the slot is empty afterwards.
- R8: `drop_cnt_o` counts each enabled event that arrives while the slot is occupied or during a high-word read, and it holds at all ones instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_en_i | input | 1 | Capture enable; 0 clears the slot |
| evt_i | input | 1 | One-cycle event pulse from the packet path |
| time_i | input | TIME_W (64) | Current time counter value |
| rd_en_i | input | 1 | Register read strobe |
| rd_hi_i | input | 1 | Word select for the read: 1 = high word, 0 = low word |
| rd_data_o | output | WORD_W (32) | Word returned one cycle after the read strobe |
| valid_o | output | 1 | Slot holds an unread stamp |
| drop_cnt_o | output | DROP_W (16) | Saturating count of refused events |

## Verification
The assertions assume that `rd_hi_i` only has meaning when `rd_en_i` is high. They also assume that an event pulse may arrive in any cycle, including one with a read or with enable low. The stimulus drives every input only on the falling clock edge. It deliberately places events on top of high-word reads and on top of a disabled enable. The bench builds the block with a narrow drop counter so that saturation is reached within a few dozen refused events.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;

  typedef enum logic {
    WSEL_LO = 1'b0,
    WSEL_HI = 1'b1
  } wsel_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/ts_cap_lock.sv
module ts_cap_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic evt_i,
  input  logic release_i,
  output logic valid_o,
  output logic cap_o,
  output logic drop_o,
  output logic clr_o
);

  logic valid_q;
  logic valid_d;

  always_comb begin
    cap_o  = en_i & evt_i & ~valid_q & ~release_i;
    drop_o = en_i & evt_i & (valid_q | release_i);
    clr_o  = ~en_i;
    if (!en_i) begin
      valid_d = 1'b0;
    end else if (release_i) begin
      valid_d = 1'b0;
    end else if (cap_o) begin
      valid_d = 1'b1;
    end else begin
      valid_d = valid_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  assign valid_o = valid_q;

  AST_CAP_DROP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_o && drop_o)); // R8

endmodule

// File: rtl/ts_cap_store.sv
module ts_cap_store #(
  parameter int unsigned TIME_W = 64,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned N_WORDS = TIME_W / WORD_W,
  localparam int unsigned SEL_W = ts_cap_pkg::idx_width(N_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_we_i,
  input  logic              clr_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic              rd_en_i,
  input  logic [SEL_W-1:0]  rd_idx_i,
  output logic [WORD_W-1:0] rd_data_o
);

  logic [N_WORDS-1:0][WORD_W-1:0] word_q;
  logic [N_WORDS-1:0][WORD_W-1:0] word_d;
  logic                           word_ce;
  logic [WORD_W-1:0]              rd_d;
  logic [WORD_W-1:0]              rd_q;

  assign word_ce = cap_we_i | clr_i;

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    always_comb begin
      if (clr_i) begin
        word_d[w] = '0;
      end else begin
        word_d[w] = time_i[w*WORD_W +: WORD_W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[w] <= '0;
      end else if (word_ce) begin
        word_q[w] <= word_d[w];
      end
    end
  end

  always_comb begin
    rd_d = word_q[rd_idx_i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_en_i) begin
      rd_q <= rd_d;
    end
  end

  assign rd_data_o = rd_q;

  AST_CLEAR_ZEROES_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (word_q == '0)); // R2

  AST_IDLE_SLOT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_we_i && !clr_i) |=> $stable(word_q)); // R4

endmodule

// File: rtl/ts_cap_drop.sv
module ts_cap_drop #(
  parameter int unsigned DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drop_i,
  output logic [DROP_W-1:0] cnt_o
);

  logic [DROP_W-1:0] cnt_q;
  logic [DROP_W-1:0] cnt_d;
  logic              cnt_ce;
  logic              at_max;

  always_comb begin
    at_max = &cnt_q;
    cnt_ce = drop_i & ~at_max;
    cnt_d  = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  AST_DROP_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '1) |=> (cnt_q == '1)); // R8

  AST_DROP_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_q >= $past(cnt_q))); // R8

endmodule

// File: rtl/ts_capture.sv
module ts_capture #(
  parameter int unsigned TIME_W = 64,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DROP_W = 16,
  localparam int unsigned N_WORDS = TIME_W / WORD_W,
  localparam int unsigned SEL_W = ts_cap_pkg::idx_width(N_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en_i,
  input  logic              evt_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic              rd_en_i,
  input  logic              rd_hi_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              valid_o,
  output logic [DROP_W-1:0] drop_cnt_o
);

  import ts_cap_pkg::*;

  wsel_e            rd_sel;
  logic             rel_hi;
  logic             cap;
  logic             drop;
  logic             clr;
  logic [SEL_W-1:0] rd_idx;

  always_comb begin
    rd_sel = wsel_e'(rd_hi_i);
    rel_hi = rd_en_i & (rd_sel == WSEL_HI);
    rd_idx = (rd_sel == WSEL_HI) ? SEL_W'(N_WORDS - 1) : '0;
  end

  ts_cap_lock u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (cap_en_i),
    .evt_i     (evt_i),
    .release_i (rel_hi),
    .valid_o   (valid_o),
    .cap_o     (cap),
    .drop_o    (drop),
    .clr_o     (clr)
  );

  ts_cap_store #(
    .TIME_W (TIME_W),
    .WORD_W (WORD_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_we_i  (cap),
    .clr_i     (clr),
    .time_i    (time_i),
    .rd_en_i   (rd_en_i),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data_o)
  );

  ts_cap_drop #(
    .DROP_W (DROP_W)
  ) u_drop (
    .clk    (clk),
    .rst_n  (rst_n),
    .drop_i (drop),
    .cnt_o  (drop_cnt_o)
  );

  AST_DISABLE_CLEARS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en_i |=> !valid_o); // R2

  AST_EVENT_ARMS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en_i && evt_i && !valid_o && !(rd_en_i && rd_hi_i)) |=> valid_o); // R3

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en_i && valid_o && !(rd_en_i && rd_hi_i)) |=> valid_o); // R4

  AST_HIGH_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && rd_hi_i) |=> !valid_o); // R6

  AST_DROP_ON_RELEASE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en_i && evt_i && rd_en_i && rd_hi_i && (drop_cnt_o != '1))
      |=> (drop_cnt_o != $past(drop_cnt_o))); // R7

endmodule

// File: tb/test_ts_capture.sv
module test_ts_capture;

  localparam int unsigned TW = 64;
  localparam int unsigned WW = 32;
  localparam int unsigned DW = 4;
  localparam int DMAX = (1 << DW) - 1;

  logic          clk;
  logic          rst_n;
  logic          cap_en_i;
  logic          evt_i;
  logic [TW-1:0] time_i;
  logic          rd_en_i;
  logic          rd_hi_i;
  logic [WW-1:0] rd_data_o;
  logic          valid_o;
  logic [DW-1:0] drop_cnt_o;

  ts_capture #(.TIME_W(TW), .WORD_W(WW), .DROP_W(DW)) i_ts_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_en_i   (cap_en_i),
    .evt_i      (evt_i),
    .time_i     (time_i),
    .rd_en_i    (rd_en_i),
    .rd_hi_i    (rd_hi_i),
    .rd_data_o  (rd_data_o),
    .valid_o    (valid_o),
    .drop_cnt_o (drop_cnt_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int    n_chk = 0;
  int    n_bad = 0;
  int    cyc = 0;
  bit    done = 0;
  string cur_req = "R1";

  // behavioural reference model
  bit              m_valid;
  longint unsigned m_stamp;
  int              m_drop;
  longint unsigned m_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid = 0; m_stamp = 0; m_drop = 0; m_rd = 0;
    end else begin
      bit rel;
      rel = rd_en_i && rd_hi_i;
      if (rd_en_i) m_rd = rd_hi_i ? (m_stamp >> 32) : (m_stamp & 64'hFFFF_FFFF);
      if (cap_en_i && evt_i && (m_valid || rel) && m_drop < DMAX) m_drop++;
      if (!cap_en_i) begin
        m_valid = 0; m_stamp = 0;
      end else if (rel) begin
        m_valid = 0;
      end else if (evt_i && !m_valid) begin
        m_valid = 1; m_stamp = time_i;
      end
    end
  end

  task automatic chk(input string tag, input longint unsigned got, input longint unsigned exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  // one clock: inputs were driven at the previous negedge; compare at this negedge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cyc++;
    chk({cur_req, " valid"}, valid_o, m_valid);
    chk({cur_req, " drop"}, drop_cnt_o, m_drop);
    chk({cur_req, " rdata"}, rd_data_o, m_rd);
    evt_i = 0; rd_en_i = 0; rd_hi_i = 0;
    time_i = {32'(cyc) + 32'h100, 32'(cyc * 13 + 5)};
  endtask

  task automatic do_evt();
    evt_i = 1; step();
  endtask

  task automatic do_rd(input bit hi);
    rd_en_i = 1; rd_hi_i = hi; step();
  endtask

  initial begin
    for (int w = 0; w < 100000; w++) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    longint unsigned a_t;
    rst_n = 0; cap_en_i = 0; evt_i = 0; rd_en_i = 0; rd_hi_i = 0; time_i = 64'h1;
    #1;
    cur_req = "R1";
    chk("R1 valid", valid_o, 0);
    chk("R1 drop", drop_cnt_o, 0);
    chk("R1 rdata", rd_data_o, 0);
    #23 rst_n = 1;
    @(negedge clk);
    step();

    // R2: disabled, events are not captured
    cur_req = "R2";
    do_evt(); do_evt();
    chk("R2 no capture", valid_o, 0);
    do_rd(0); chk("R2 low word zero", rd_data_o, 0);

    // R3: capture
    cur_req = "R3";
    cap_en_i = 1; step();
    a_t = time_i;
    do_evt();
    chk("R3 valid set", valid_o, 1);

    // R5: low read keeps lock
    cur_req = "R5";
    do_rd(0);
    chk("R5 low word", rd_data_o, a_t & 64'hFFFF_FFFF);
    chk("R5 still valid", valid_o, 1);

    // R4: events while locked ignored
    cur_req = "R4";
    do_evt(); do_evt();
    do_rd(0);
    chk("R4 stamp unchanged", rd_data_o, a_t & 64'hFFFF_FFFF);
    chk("R4 drops counted", drop_cnt_o, 2);

    // R6: high read releases and rearms
    cur_req = "R6";
    do_rd(1);
    chk("R6 high word", rd_data_o, a_t >> 32);
    chk("R6 released", valid_o, 0);
    a_t = time_i;
    do_evt();
    chk("R6 rearmed", valid_o, 1);
    do_rd(0);
    chk("R6 new stamp", rd_data_o, a_t & 64'hFFFF_FFFF);

    // R7: event on top of high read
    cur_req = "R7";
    evt_i = 1; do_rd(1);
    chk("R7 slot empty", valid_o, 0);
    chk("R7 drop counted", drop_cnt_o, 3);
    step();
    chk("R7 still empty", valid_o, 0);

    // R2: disabling clears a held stamp, drop count kept
    cur_req = "R2";
    do_evt();
    cap_en_i = 0; evt_i = 1; step();
    chk("R2 valid cleared", valid_o, 0);
    chk("R2 drop kept", drop_cnt_o, 3);
    cap_en_i = 1; do_rd(0);
    chk("R2 stamp cleared", rd_data_o, 0);
    do_rd(1);
    chk("R2 high cleared", rd_data_o, 0);

    // R8: saturation
    cur_req = "R8";
    do_evt();
    for (int k = 0; k < 20; k++) do_evt();
    chk("R8 saturated", drop_cnt_o, DMAX);
    do_evt();
    chk("R8 no wrap", drop_cnt_o, DMAX);

    // mixed traffic
    cur_req = "R3";
    for (int k = 0; k < 40; k++) begin
      cap_en_i = (k % 11) != 7;
      evt_i = (k % 3) == 0;
      if ((k % 5) == 2) begin rd_en_i = 1; rd_hi_i = (k % 2); end
      step();
    end

    finish_run();
  end

endmodule